// File: doc/BRIEF.md
# SPI Slave Transceiver with Double Buffering

This block is an 8-bit SPI slave that runs from the system clock. The master drives the bit clock, the data line from master to slave and an active-low select line. All three pass through synchronizers, and their edges are detected in the system clock domain. As a result, the serial clock may run at no more than a quarter of the system clock.

A single shift register carries traffic in both directions. Each bit taken from the master is matched by one bit sent back to it. The host loads outgoing bytes into a transmit holding register and collects incoming bytes from a receive holding register. Two configuration inputs set clock polarity and clock phase, which together select one of the four standard SPI modes. Five status flags report the state of the block:
- transmit holding empty
- receive holding full
- byte complete
- overrun
- underrun

At the end of each byte, the received word moves to the receive holding register. In the same system cycle, the next transmit byte moves into the shift register, so bytes can follow one another with no gap.

Top module: `spi_slave_xcvr`

## Requirements
- R1: `cfg_cpol` gives the idle level of the serial clock, and the leading edge is the first edge away from that level. With `cfg_cpha`=0, the slave samples the master's data on leading edges and changes `miso_o` on trailing edges. With `cfg_cpha`=1, it changes `miso_o` on leading edges and samples on trailing edges. Both directions send the most significant bit first.
- R2: In every mode, the byte the master clocks out lands in `rx_data` unchanged, and the master clocks in the transmit byte that the host queued.
- R3: When select falls, the shift register loads the transmit holding byte and `st_tx_empty` rises. A `tx_wr` pulse stores `tx_data` and clears `st_tx_empty` on the next cycle.
- R4: On the eighth sample edge of a byte, `rx_data` takes the received byte and `st_rx_full` and `st_done` rise. In the same cycle, a queued transmit byte moves into the shift register, so a following byte needs no idle clocks.
- R5: If no transmit byte is queued when a load happens, the shift register loads 0xFF, the master reads 0xFF, and `st_underrun` rises.
- R6: If a byte completes while `st_rx_full` is still set and no `rx_rd` arrives in that cycle, `st_overrun` rises and `rx_data` is overwritten with the newest byte.
- R7: A `status_rd` pulse clears `st_done`, `st_overrun` and `st_underrun` and leaves `st_tx_empty` and `st_rx_full` unchanged. A `rx_rd` pulse clears `st_rx_full`.
- R8: While select is high, `miso_oe_o` is 0 and the bit count is held at zero. A byte cut short by select rising is discarded, and the next selection starts again from bit 7.
- R9: After reset, `st_tx_empty`=1, the other four flags are 0, and `miso_oe_o`=0.
- R10: Serial clock edges while select is high change neither the data nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Clock polarity (idle level of the serial clock) |
| cfg_cpha | input | 1 | Clock phase (0: sample on leading edge, 1: sample on trailing edge) |
| sclk_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| tx_wr | input | 1 | Host strobe that writes the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Host strobe that acknowledges a read of the receive holding register |
| rx_data | output | 8 | Last byte received |
| status_rd | input | 1 | Host strobe that clears the sticky flags |
| st_tx_empty | output | 1 | Transmit holding register empty |
| st_rx_full | output | 1 | Receive holding register holds an unread byte |
| st_done | output | 1 | A byte has completed (sticky) |
| st_overrun | output | 1 | A received byte overwrote an unread one (sticky) |
| st_underrun | output | 1 | 0xFF was sent because no byte was queued (sticky) |

## Verification
The bench runs every clock mode through back-to-back bytes, a run of underruns and a double receive without a read. A design that shifts on the wrong edge or at the wrong phase returns bytes displaced by one bit. A design that lets the first shift edge after a load through drops bit 7 at each byte boundary. The bench also cuts a byte short and then toggles the serial clock while deselected. A design whose counter survives deselection then misframes the following byte, and one that fails to gate those edges corrupts the next transfer. Last, the bench clears the flags with `status_rd` and checks that the two level flags survive the clear while the sticky ones drop.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // Status flags carried between the holding-register logic and the top.
  typedef struct packed {
    logic underrun;
    logic overrun;
    logic done;
    logic rx_full;
    logic tx_empty;
  } spi_slv_status_t;

  localparam int unsigned SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/spi_slv_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module spi_slv_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RSTV  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RSTV;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RSTV;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
// Turns synchronized clock and select levels into per-mode strobes.
module spi_slv_edge (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic cpha,
  input  logic sclk_s,
  input  logic ss_n_s,
  output logic active,
  output logic start,
  output logic sample_stb,
  output logic shift_stb
);
  logic sclk_q;
  logic ss_q;
  logic rise, fall, lead, trail;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_n_s;
    end
  end

  always_comb begin
    rise       = sclk_s & ~sclk_q;
    fall       = ~sclk_s & sclk_q;
    lead       = cpol ? fall : rise;
    trail      = cpol ? rise : fall;
    active     = ~ss_n_s;
    start      = ss_q & ~ss_n_s;
    sample_stb = active & ~start & (cpha ? trail : lead);
    shift_stb  = active & ~start & (cpha ? lead : trail);
  end
endmodule

// File: rtl/spi_slv_shifter.sv
// Shared shift register, bit counter and byte-boundary reload.
module spi_slv_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpha,
  input  logic         active,
  input  logic         start,
  input  logic         sample_stb,
  input  logic         shift_stb,
  input  logic         mosi_s,
  input  logic         tx_avail,
  input  logic [W-1:0] tx_word,
  output logic         take,
  output logic         underrun_ev,
  output logic         done_ev,
  output logic [W-1:0] rx_word,
  output logic         miso
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          smp;
  logic          fresh;   // suppresses the first shift edge after a load
  logic          load;
  logic [W-1:0]  load_val;

  always_comb begin
    done_ev     = active & sample_stb & (cnt == LAST);
    load        = start | done_ev;
    take        = load & tx_avail;
    underrun_ev = load & ~tx_avail;
    load_val    = tx_avail ? tx_word : '1;
    rx_word     = {sr[W-2:0], mosi_s};
    miso        = sr[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '1;
      cnt   <= '0;
      smp   <= 1'b0;
      fresh <= 1'b0;
    end else if (start) begin
      sr    <= load_val;
      cnt   <= '0;
      fresh <= cpha;
    end else if (!active) begin
      cnt   <= '0;
      fresh <= 1'b0;
    end else begin
      if (sample_stb) begin
        smp <= mosi_s;
        if (cnt == LAST) begin
          sr    <= load_val;
          cnt   <= '0;
          fresh <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (shift_stb) begin
        if (fresh) fresh <= 1'b0;
        else       sr    <= {sr[W-2:0], smp};
      end
    end
  end
endmodule

// File: rtl/spi_slv_regs.sv
// Host-side holding registers and status flags.
module spi_slv_regs
  import spi_slv_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_wr,
  input  logic [W-1:0]    tx_data,
  input  logic            rx_rd,
  input  logic            status_rd,
  input  logic            take,
  input  logic            underrun_ev,
  input  logic            done_ev,
  input  logic [W-1:0]    rx_word,
  output logic            tx_avail,
  output logic [W-1:0]    tx_word,
  output logic [W-1:0]    rx_hold,
  output spi_slv_status_t status
);
  logic tx_full, rx_full, done_f, ovr_f, und_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word <= '0;
      tx_full <= 1'b0;
    end else if (tx_wr) begin
      tx_word <= tx_data;
      tx_full <= 1'b1;
    end else if (take) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= '0;
      rx_full <= 1'b0;
    end else if (done_ev) begin
      rx_hold <= rx_word;
      rx_full <= 1'b1;
    end else if (rx_rd) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_f <= 1'b0;
      ovr_f  <= 1'b0;
      und_f  <= 1'b0;
    end else begin
      done_f <= done_ev | (done_f & ~status_rd);
      ovr_f  <= (done_ev & rx_full & ~rx_rd) | (ovr_f & ~status_rd);
      und_f  <= underrun_ev | (und_f & ~status_rd);
    end
  end

  always_comb begin
    tx_avail        = tx_full;
    status.tx_empty = ~tx_full;
    status.rx_full  = rx_full;
    status.done     = done_f;
    status.overrun  = ovr_f;
    status.underrun = und_f;
  end
endmodule

// File: rtl/spi_slave_xcvr.sv
module spi_slave_xcvr
  import spi_slv_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_data,
  input  logic              status_rd,
  output logic              st_tx_empty,
  output logic              st_rx_full,
  output logic              st_done,
  output logic              st_overrun,
  output logic              st_underrun
);
  logic [2:0] pins_s;
  logic sclk_s, ss_n_s, mosi_s;
  logic active, start, sample_stb, shift_stb;
  logic take, underrun_ev, done_ev, tx_avail, miso_bit;
  logic [WORD_W-1:0] tx_word, rx_word;
  spi_slv_status_t status;
  logic oe_r;

  spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES), .RSTV(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sclk_i, ss_n_i, mosi_i}), .q(pins_s)
  );
  assign {sclk_s, ss_n_s, mosi_s} = pins_s;

  spi_slv_edge u_edge (
    .clk(clk), .rst(rst), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .sclk_s(sclk_s), .ss_n_s(ss_n_s), .active(active), .start(start),
    .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  spi_slv_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .cpha(cfg_cpha), .active(active), .start(start),
    .sample_stb(sample_stb), .shift_stb(shift_stb), .mosi_s(mosi_s),
    .tx_avail(tx_avail), .tx_word(tx_word), .take(take),
    .underrun_ev(underrun_ev), .done_ev(done_ev), .rx_word(rx_word),
    .miso(miso_bit)
  );

  spi_slv_regs #(.W(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .status_rd(status_rd), .take(take), .underrun_ev(underrun_ev),
    .done_ev(done_ev), .rx_word(rx_word), .tx_avail(tx_avail),
    .tx_word(tx_word), .rx_hold(rx_data), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_r <= 1'b0;
    else     oe_r <= active;
  end

  assign miso_o      = miso_bit;
  assign miso_oe_o   = oe_r;
  assign st_tx_empty = status.tx_empty;
  assign st_rx_full  = status.rx_full;
  assign st_done     = status.done;
  assign st_overrun  = status.overrun;
  assign st_underrun = status.underrun;
endmodule

// File: rtl/spi_slv_checker.sv
module spi_slv_checker #(
  parameter int unsigned W = 8
) (
  input logic clk,
  input logic rst,
  input logic miso_o,
  input logic miso_oe_o,
  input logic tx_wr,
  input logic rx_rd,
  input logic status_rd,
  input logic st_tx_empty,
  input logic st_rx_full,
  input logic st_done,
  input logic st_overrun,
  input logic st_underrun,
  input logic active,
  input logic sample_stb,
  input logic shift_stb,
  input logic done_ev,
  input logic underrun_ev
);
  localparam int unsigned CW = $clog2(W) + 1;
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !active || done_ev) bcnt <= '0;
    else if (sample_stb)          bcnt <= bcnt + 1'b1;
  end

  assert_oe_off_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !active |=> !miso_oe_o);
  assert_byte_is_w_samples_R4: assert property (@(posedge clk) disable iff (rst)
    done_ev |-> (bcnt == CW'(W - 1)));
  assert_done_sets_flags_R4: assert property (@(posedge clk) disable iff (rst)
    done_ev |=> (st_rx_full && st_done));
  assert_write_fills_tx_R3: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !st_tx_empty);
  assert_underrun_sends_ones_R5: assert property (@(posedge clk) disable iff (rst)
    underrun_ev |=> (miso_o && st_underrun));
  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (done_ev && st_rx_full && !rx_rd) |=> st_overrun);
  assert_read_clears_full_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !done_ev) |=> !st_rx_full);
  assert_status_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !done_ev && !underrun_ev) |=> (!st_done && !st_overrun && !st_underrun));
  assert_edges_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_stb, shift_stb}));
endmodule

bind spi_slave_xcvr spi_slv_checker #(.W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
  .tx_wr(tx_wr), .rx_rd(rx_rd), .status_rd(status_rd),
  .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full), .st_done(st_done),
  .st_overrun(st_overrun), .st_underrun(st_underrun), .active(active),
  .sample_stb(sample_stb), .shift_stb(shift_stb), .done_ev(done_ev),
  .underrun_ev(underrun_ev)
);

// File: tb/tb_spi_slave_xcvr.sv
module tb_spi_slave_xcvr;
  localparam int H = 8;  // serial half period in system cycles
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic sclk_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
  logic miso_o, miso_oe_o;
  logic tx_wr = 1'b0, rx_rd = 1'b0, status_rd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic st_tx_empty, st_rx_full, st_done, st_overrun, st_underrun;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_slave_xcvr dut (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o),
    .miso_oe_o(miso_oe_o), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .rx_data(rx_data), .status_rd(status_rd), .st_tx_empty(st_tx_empty),
    .st_rx_full(st_rx_full), .st_done(st_done), .st_overrun(st_overrun),
    .st_underrun(st_underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_rx_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic pulse_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  // Master side of one byte; nbits < 8 cuts the byte short.
  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    for (int b = 7; b > 7 - nbits; b--) begin
      if (!cfg_cpha) begin
        @(negedge clk); mosi_i = mo[b];
        cyc(H);
        sclk_i = ~cfg_cpol; mi[b] = miso_o;
        cyc(H);
        sclk_i = cfg_cpol;
      end else begin
        @(negedge clk); sclk_i = ~cfg_cpol; mosi_i = mo[b];
        cyc(H);
        sclk_i = cfg_cpol; mi[b] = miso_o;
        cyc(H);
      end
    end
    cyc(6);
  endtask

  task automatic select();
    @(negedge clk); ss_n_i = 1'b0;
    cyc(H);
  endtask

  task automatic deselect();
    @(negedge clk); ss_n_i = 1'b1;
    cyc(6);
  endtask

  function automatic logic [7:0] txpat(input int m, input int k);
    return 8'((k * 53 + m * 29 + 7) & 255);
  endfunction
  function automatic logic [7:0] mopat(input int m, input int k);
    return 8'(((k * 91 + m * 17 + 200) & 255) ^ 8'h5A);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] mi;
    cyc(5);
    rst = 1'b0;
    cyc(2);
    // R9 reset state
    chk("R9 tx_empty", st_tx_empty, 1);
    chk("R9 rx_full", st_rx_full, 0);
    chk("R9 sticky flags", {st_done, st_overrun, st_underrun}, 0);
    chk("R9 oe", miso_oe_o, 0);

    for (int m = 0; m < 4; m++) begin
      cfg_cpol = m[1]; cfg_cpha = m[0];
      @(negedge clk); sclk_i = cfg_cpol;
      cyc(6);
      pulse_status();
      write_tx(txpat(m, 0));
      chk("R3 write clears empty", st_tx_empty, 0);
      select();
      chk("R8 oe while selected", miso_oe_o, 1);
      for (int k = 0; k < 4; k++) begin
        chk("R3 load empties tx", st_tx_empty, 1);
        if (k < 3) write_tx(txpat(m, k + 1));
        xfer(mopat(m, k), 8, mi);
        chk("R2 master receives tx byte", mi, txpat(m, k));
        chk("R4 rx_full after byte", st_rx_full, 1);
        chk("R2 rx_data", rx_data, mopat(m, k));
        chk("R4 done set", st_done, 1);
        pulse_rx_rd();
        chk("R7 rx_rd clears full", st_rx_full, 0);
      end
      // R5: the last boundary found nothing queued
      chk("R5 underrun flag", st_underrun, 1);
      xfer(8'hA5 ^ 8'(m), 8, mi);
      chk("R5 master reads ones", mi, 8'hFF);
      chk("R6 no overrun yet", st_overrun, 0);
      xfer(8'h3C ^ 8'(m), 8, mi);
      chk("R5 second underrun byte", mi, 8'hFF);
      chk("R6 overrun flag", st_overrun, 1);
      chk("R6 newest byte kept", rx_data, 8'h3C ^ 8'(m));
      pulse_status();
      chk("R7 sticky flags cleared", {st_done, st_overrun, st_underrun}, 0);
      chk("R7 level flags kept", {st_rx_full, st_tx_empty}, 2'b11);
      pulse_rx_rd();
      deselect();
      chk("R8 oe off after deselect", miso_oe_o, 0);

      // R8: aborted partial byte, then a clean byte
      write_tx(8'h81 ^ 8'(m));
      select();
      xfer(8'hF0, 3, mi);
      deselect();
      chk("R8 aborted byte discarded", {st_rx_full, st_done}, 0);
      // R10: clock activity while deselected
      for (int t = 0; t < 10; t++) begin
        @(negedge clk); mosi_i = t[0]; sclk_i = ~sclk_i;
        cyc(H);
      end
      @(negedge clk); sclk_i = cfg_cpol;
      cyc(6);
      chk("R10 no effect while deselected", {st_rx_full, st_done, st_overrun}, 0);
      write_tx(txpat(m, 9));
      select();
      xfer(mopat(m, 9), 8, mi);
      chk("R8 realigned tx byte", mi, txpat(m, 9));
      chk("R10 rx byte after idle clocks", rx_data, mopat(m, 9));
      chk("R1 mode byte complete", st_rx_full, 1);
      pulse_rx_rd();
      deselect();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule